// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs from its own slow clock, separate from the system clock, so it keeps counting even if the system clock stops. Software talks to it through a small register port in the system clock domain. The port has four word addresses: a key register, a divider select, a reload value and a status word. Once the watchdog is started, a 12-bit counter in the watchdog domain counts down through a programmable divider. If software does not refresh it in time, the counter reaches zero and the block emits a system-reset request pulse. After the pulse, the counter restarts from the reload value.

Everything is driven by 16-bit keys written to address 0. One key starts the watchdog and another refreshes the counter. A third key opens the divider and reload registers for writing, and the start and refresh keys close them again. A new divider or reload value crosses into the watchdog domain through a toggle request/acknowledge handshake. A status bit shows that the transfer is still in progress, and further writes to that register are dropped until it completes.

Top module: `watchdog_key_timer`

## Requirements
- R1: After reset, reads return 0 at address 1 (divider code), 0xFFF at address 2 (reload), 0 at address 3 (status) and 0 at address 0. The reset request stays low while the watchdog has not been started.
- R2: Writing 0xCCCC to address 0 starts the counter from 0xFFF with divider code 0 (divide by 4). The first reset request rises about 0xFFF*4 watchdog clock cycles later.
- R3: The reset request is a pulse of exactly RST_CYCLES (default 8) watchdog clock cycles. From the cycle it falls to the cycle the next unrefreshed pulse rises is reload*divide+1 watchdog cycles.
- R4: Writing 0xAAAA to address 0 reloads the counter from the reload value and restarts the divider. Refreshing more often than the timeout keeps the reset request low.
- R5: Writes to address 1 or address 2 change nothing unless 0x5555 has been written to address 0 first. Writing 0xAAAA or 0xCCCC locks them again. Any other key value neither unlocks nor locks.
- R6: Divider code n in 0..6 (address 1, bits 2:0) divides the watchdog clock by 4<<n. Code 7 divides by 256.
- R7: Status bit 0 (divider update busy) and bit 1 (reload update busy) read 1 right after an accepted write. They clear once the new value has reached the watchdog domain. A write to a register whose busy bit is set is dropped.
- R8: After start, no key write stops the watchdog, and reset pulses keep coming without refreshes.
- R9: A refresh that arrives while a reset pulse is in progress is ignored. The pulse keeps its full length, and the next timeout is measured from the pulse's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (bus) clock |
| sys_rst_n | input | 1 | Active-low async reset, bus domain |
| wd_clk | input | 1 | Dedicated low-speed watchdog clock |
| wd_rst_n | input | 1 | Active-low async reset, watchdog domain |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address: 0 key, 1 divider, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| wd_reset_req | output | 1 | System-reset request pulse, watchdog domain |

## Verification
The refresh key and the expiry of the counter can coincide. The hard case is a refresh that reaches the watchdog domain while the reset pulse for an expired count is already under way. The bench provokes this by waiting for the rising edge of the request and issuing a refresh zero to three watchdog cycles later, so that the synchronized refresh lands inside the pulse. Each case is judged by requiring the pulse to stay exactly RST_CYCLES long and the next pulse to follow its end after reload*divide+1 cycles, which shows that the refresh neither cut the pulse short nor shifted the count.

// File: rtl/watchdog_key_timer.sv
module watchdog_key_timer #(
  parameter int CNT_W      = 12,
  parameter int PS_W       = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic        sys_clk,
  input  logic        sys_rst_n,
  input  logic        wd_clk,
  input  logic        wd_rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        wd_reset_req
);
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam int PC_W = 8;
  localparam int PL_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};

  logic             unlocked;
  logic [PS_W-1:0]  pr_q;
  logic [CNT_W-1:0] rl_q;
  logic             pr_req, rl_req, st_tgl, rf_tgl;
  logic [1:0]       pa_s, ra_s;
  logic             pr_ack, rl_ack;

  wire key_wr  = bus_we && (bus_addr == 2'd0);
  wire pr_busy = pr_req ^ pa_s[1];
  wire rl_busy = rl_req ^ ra_s[1];
  wire pr_acc  = bus_we && (bus_addr == 2'd1) && unlocked && !pr_busy;
  wire rl_acc  = bus_we && (bus_addr == 2'd2) && unlocked && !rl_busy;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      unlocked <= 1'b0;
      pr_q     <= '0;
      rl_q     <= CNT_INIT;
      pr_req   <= 1'b0;
      rl_req   <= 1'b0;
      st_tgl   <= 1'b0;
      rf_tgl   <= 1'b0;
      pa_s     <= '0;
      ra_s     <= '0;
    end else begin
      pa_s <= {pa_s[0], pr_ack};
      ra_s <= {ra_s[0], rl_ack};
      if (key_wr) begin
        if (bus_wdata == KEY_UNLOCK) unlocked <= 1'b1;
        if (bus_wdata == KEY_REFRESH) begin
          unlocked <= 1'b0;
          rf_tgl   <= ~rf_tgl;
        end
        if (bus_wdata == KEY_START) begin
          unlocked <= 1'b0;
          st_tgl   <= ~st_tgl;
        end
      end
      if (pr_acc) begin
        pr_q   <= bus_wdata[PS_W-1:0];
        pr_req <= ~pr_req;
      end
      if (rl_acc) begin
        rl_q   <= bus_wdata[CNT_W-1:0];
        rl_req <= ~rl_req;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd1:    bus_rdata[PS_W-1:0]  = pr_q;
      2'd2:    bus_rdata[CNT_W-1:0] = rl_q;
      2'd3:    bus_rdata[1:0]       = {rl_busy, pr_busy};
      default: bus_rdata = '0;
    endcase
  end

  logic [2:0]       st_s, rf_s;
  logic [1:0]       prq_s, rlq_s;
  logic [PS_W-1:0]  wd_pr;
  logic [CNT_W-1:0] wd_rl;
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  pcnt;
  logic [PL_W-1:0]  plen;
  logic             running, pulsing;

  wire start_ev   = st_s[2] ^ st_s[1];
  wire refresh_ev = rf_s[2] ^ rf_s[1];
  wire [2:0] ps_sel = (wd_pr >= PS_W'(6)) ? 3'd6 : 3'(wd_pr);
  wire [8:0] div_m1 = (9'd4 << ps_sel) - 9'd1;
  wire tick = running && ({1'b0, pcnt} >= div_m1);

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      st_s    <= '0;
      rf_s    <= '0;
      prq_s   <= '0;
      rlq_s   <= '0;
      pr_ack  <= 1'b0;
      rl_ack  <= 1'b0;
      wd_pr   <= '0;
      wd_rl   <= CNT_INIT;
      cnt     <= CNT_INIT;
      pcnt    <= '0;
      plen    <= '0;
      running <= 1'b0;
      pulsing <= 1'b0;
    end else begin
      st_s  <= {st_s[1:0], st_tgl};
      rf_s  <= {rf_s[1:0], rf_tgl};
      prq_s <= {prq_s[0], pr_req};
      rlq_s <= {rlq_s[0], rl_req};
      if (prq_s[1] != pr_ack) begin
        wd_pr  <= pr_q;
        pr_ack <= prq_s[1];
      end
      if (rlq_s[1] != rl_ack) begin
        wd_rl  <= rl_q;
        rl_ack <= rlq_s[1];
      end
      if (start_ev) running <= 1'b1;
      if (pulsing) begin
        if (plen == PL_W'(1)) begin
          pulsing <= 1'b0;
          cnt     <= wd_rl;
          pcnt    <= '0;
        end
        plen <= plen - PL_W'(1);
      end else if (refresh_ev) begin
        cnt  <= wd_rl;
        pcnt <= '0;
      end else if (running && cnt == '0) begin
        pulsing <= 1'b1;
        plen    <= PL_W'(RST_CYCLES);
      end else if (tick) begin
        cnt  <= cnt - CNT_W'(1);
        pcnt <= '0;
      end else if (running) begin
        pcnt <= pcnt + PC_W'(1);
      end
    end
  end

  assign wd_reset_req = pulsing;
endmodule

module watchdog_key_timer_chk #(
  parameter int PS_W       = 3,
  parameter int CNT_W      = 12,
  parameter int RST_CYCLES = 8
) (
  input logic             sys_clk,
  input logic             sys_rst_n,
  input logic             wd_clk,
  input logic             wd_rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic             unlocked,
  input logic [PS_W-1:0]  pr_q,
  input logic [CNT_W-1:0] rl_q,
  input logic             pr_busy,
  input logic             rl_busy,
  input logic             running,
  input logic             wd_reset_req
);
  logic [15:0] hi_len;
  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) hi_len <= '0;
    else if (wd_reset_req) hi_len <= hi_len + 16'd1;
    else hi_len <= '0;
  end

  AST_LOCK_PR: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 2'd1 && !unlocked) |=> $stable(pr_q)); // R5
  AST_LOCK_RL: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 2'd2 && !unlocked) |=> $stable(rl_q)); // R5
  AST_RELOCK: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 2'd0 && (bus_wdata == 16'hAAAA || bus_wdata == 16'hCCCC)) |=> !unlocked); // R5
  AST_BUSY_HOLD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 2'd1 && pr_busy) |=> $stable(pr_q)); // R7
  AST_BUSY_SET: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr == 2'd2 && unlocked && !rl_busy) |=> rl_busy); // R7
  AST_NO_STOP: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    running |=> running); // R8
  AST_PULSE_LEN: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (hi_len != 16'd0 && !wd_reset_req) |-> (hi_len == 16'(RST_CYCLES))); // R3
  AST_PULSE_MAX: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    hi_len <= 16'(RST_CYCLES)); // R3
endmodule

bind watchdog_key_timer watchdog_key_timer_chk #(
  .PS_W(PS_W), .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .unlocked(unlocked), .pr_q(pr_q), .rl_q(rl_q), .pr_busy(pr_busy), .rl_busy(rl_busy),
  .running(running), .wd_reset_req(wd_reset_req)
);

// File: tb/sim_watchdog_key_timer.sv
module sim_watchdog_key_timer;
  logic sys_clk = 0, wd_clk = 0, sys_rst_n = 0, wd_rst_n = 0;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic wd_reset_req;

  always #2.5 sys_clk = ~sys_clk;
  always #5.5 wd_clk = ~wd_clk;

  watchdog_key_timer u0 (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_reset_req(wd_reset_req)
  );

  int checks = 0, errors = 0;
  int wdcyc = 0, n_rise = 0, n_fall = 0, rise_c = 0, fall_c = 0, cur_w = 0, last_w = 0;
  int bad_w = 0;
  logic prev_req = 0;

  always @(negedge wd_clk) begin
    wdcyc++;
    if (wd_reset_req && !prev_req) begin rise_c = wdcyc; cur_w = 1; n_rise++; end
    else if (wd_reset_req) cur_w++;
    if (!wd_reset_req && prev_req) begin
      fall_c = wdcyc; last_w = cur_w; n_fall++;
      if (cur_w != 8) bad_w++;
    end
    prev_req = wd_reset_req;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int syscyc = 0;
  always @(posedge sys_clk) begin
    syscyc++;
    if (syscyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", syscyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge sys_clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge sys_clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge sys_clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic wait_wd(input int n);
    repeat (n) @(negedge wd_clk);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(2'd3, s);
      if (s[1:0] == 2'b00) break;
    end
  endtask

  task automatic wait_rise(input int tmo);
    int n0 = n_rise;
    for (int i = 0; i < tmo && n_rise == n0; i++) @(negedge wd_clk);
  endtask

  task automatic wait_fall(input int tmo);
    int n0 = n_fall;
    for (int i = 0; i < tmo && n_fall == n0; i++) @(negedge wd_clk);
  endtask

  task automatic set_cfg(input logic [2:0] code, input logic [11:0] rl);
    wr(2'd0, 16'h5555);
    wr(2'd1, {13'd0, code});
    wr(2'd2, {4'd0, rl});
    wait_idle();
    wr(2'd0, 16'hAAAA);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk(v == 16'h0, "R1 key read", v, 0);
    rd(2'd1, v); chk(v == 16'h0, "R1 divider", v, 0);
    rd(2'd2, v); chk(v == 16'h0FFF, "R1 reload", v, 16'h0FFF);
    rd(2'd3, v); chk(v == 16'h0, "R1 status", v, 0);
    wait_wd(300);
    chk(n_rise == 0, "R1 no pulse before start", n_rise, 0);
  endtask

  task automatic t_first_timeout();
    int t0;
    wr(2'd0, 16'hCCCC);
    t0 = wdcyc;
    wait_rise(17000);
    chk(n_rise == 1 && (rise_c - t0) >= 16380 && (rise_c - t0) <= 16392,
        "R2 first timeout", rise_c - t0, 16384);
    wait_fall(50);
    chk(last_w == 8, "R3 pulse width", last_w, 8);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    wr(2'd1, 16'd3); wr(2'd2, 16'd10); wait_wd(10);
    rd(2'd1, v); chk(v == 16'd0, "R5 divider locked", v, 0);
    rd(2'd2, v); chk(v == 16'h0FFF, "R5 reload locked", v, 16'h0FFF);
    wr(2'd0, 16'h1234); wr(2'd2, 16'd10); wait_wd(10);
    rd(2'd2, v); chk(v == 16'h0FFF, "R5 other key no unlock", v, 16'h0FFF);
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd2, 16'd10); wait_idle();
    rd(2'd2, v); chk(v == 16'd10, "R5 unlocked write", v, 10);
    wr(2'd0, 16'hAAAA); wr(2'd2, 16'd20); wait_wd(10);
    rd(2'd2, v); chk(v == 16'd10, "R5 refresh relocks", v, 10);
    wr(2'd0, 16'h5555); wr(2'd0, 16'hCCCC); wr(2'd1, 16'd2); wait_wd(10);
    rd(2'd1, v); chk(v == 16'd0, "R5 start relocks", v, 0);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd1);
    rd(2'd3, v); chk(v[0] == 1'b1, "R7 divider busy set", v, 1);
    wr(2'd1, 16'd5);
    wait_idle();
    rd(2'd3, v); chk(v == 16'd0, "R7 divider busy clears", v, 0);
    rd(2'd1, v); chk(v == 16'd1, "R7 write while busy dropped", v, 1);
    wr(2'd2, 16'd30);
    rd(2'd3, v); chk(v[1] == 1'b1, "R7 reload busy set", v, 2);
    wr(2'd2, 16'd40);
    wait_idle();
    rd(2'd3, v); chk(v == 16'd0, "R7 reload busy clears", v, 0);
    rd(2'd2, v); chk(v == 16'd30, "R7 reload write while busy dropped", v, 30);
    wr(2'd0, 16'hAAAA);
  endtask

  task automatic t_prescale();
    for (int code = 0; code < 8; code++) begin
      int dv = (code == 7) ? 256 : (4 << code);
      int gap;
      set_cfg(3'(code), 12'd10);
      wait_wd(20);
      wait_fall(3000);
      wait_rise(3000);
      gap = rise_c - fall_c;
      chk(gap >= 10*dv && gap <= 10*dv + 2, "R6 divider period", gap, 10*dv + 1);
    end
    set_cfg(3'd0, 12'd10);
    wait_wd(20);
    wait_fall(200);
    wait_rise(200);
    chk(rise_c - fall_c == 41, "R3 gap after pulse", rise_c - fall_c, 41);
  endtask

  task automatic t_refresh();
    int n0;
    wait_fall(200);
    wr(2'd0, 16'hAAAA);
    wait_wd(10);
    n0 = n_rise;
    for (int i = 0; i < 30; i++) begin
      wr(2'd0, 16'hAAAA);
      wait_wd(15);
    end
    chk(n_rise == n0, "R4 refresh holds off reset", n_rise - n0, 0);
    wait_rise(100);
    chk(n_rise == n0 + 1, "R4 timeout after refresh stops", n_rise - n0, 1);
  endtask

  task automatic t_nostop();
    int n0 = n_rise;
    wr(2'd0, 16'h0000); wr(2'd0, 16'hFFFF); wr(2'd0, 16'h5555); wr(2'd0, 16'h1234);
    wait_wd(250);
    chk(n_rise - n0 >= 3, "R8 cannot be stopped", n_rise - n0, 4);
    wr(2'd0, 16'hCCCC);
    wait_wd(100);
    chk(n_rise - n0 >= 5, "R8 start again keeps running", n_rise - n0, 6);
  endtask

  task automatic t_collide();
    for (int off = 0; off < 4; off++) begin
      wait_rise(200);
      wait_wd(off);
      wr(2'd0, 16'hAAAA);
      wait_fall(50);
      chk(last_w == 8, "R9 pulse width with refresh", last_w, 8);
      wait_rise(200);
      chk(rise_c - fall_c == 41, "R9 refresh ignored in pulse", rise_c - fall_c, 41);
    end
    chk(bad_w == 0, "R3 all pulse widths", bad_w, 0);
  endtask

  initial begin
    #40 sys_rst_n = 1; wd_rst_n = 1;
    t_reset();
    t_first_timeout();
    t_lock();
    t_busy();
    t_prescale();
    t_refresh();
    t_nostop();
    t_collide();
    summary();
  end
endmodule